// File: doc/BRIEF.md
# Packed YCbCr Display Unpacker

This block feeds a byte-wide video display output from three separate sample queues, one each for luma (Y), blue-difference chroma (Cb) and red-difference chroma (Cr). Every queue delivers 64-bit words, and each word carries eight 8-bit samples. The block keeps one word per queue in a holding register and sends its samples out one at a time. The output follows the interleaved component order Cb, Y, Cr, Y, so the luma queue empties twice as fast as either chroma queue.

A mode input selects the order in which bytes are taken from a word. In little-endian order the lowest byte goes first. In big-endian order the highest byte goes first. The mode is captured only while no queue word is held, so one word is never split across two orders. Output pacing comes from a clock-enable input, and each accepted enable produces at most one sample. If the queue needed for the next sample has nothing ready, the block waits. It never skips a component and never reorders the stream.

Top module: `ycbcr_unpacker`

## Requirements
- R1: Each queue handshake (valid and ready high at a clock edge) moves one 64-bit word, which holds eight 8-bit samples. A queue's ready is high only while its holding register is empty, so a new word is requested only after all eight samples of the previous word have been sent.
- R2: With big_endian low, the k-th sample taken from a word (k = 0..7) is bits 8k+7 down to 8k.
- R3: With big_endian high, the k-th sample taken from a word is bits 63-8k down to 56-8k.
- R4: Samples leave in the repeating order Cb, Y, Cr, Y. Output n (counted from 0 after reset) is Cb sample n/4 when n mod 4 = 0, Cr sample n/4 when n mod 4 = 2, and Y sample n/2 when n is odd.
- R5: A sample is placed on vd_out[9:2], and vd_out[1:0] is zero whenever vd_valid is high.
- R6: vd_valid is high for exactly the cycle after a clock edge at which pix_ce was high and a sample was emitted. It is never high after an edge with pix_ce low.
- R7: If the queue for the next sample in the order has no word held at an enabled edge, vd_valid is low in the following cycle. The sequence then resumes with that same component, without skipping or reordering.
- R8: A synchronous active-high reset clears the holding registers and byte positions and restarts the order at Cb. In the cycle after reset, vd_valid is low and all three ready outputs are high. The byte-order mode is taken from big_endian while reset is held.
- R9: Outside reset, big_endian is captured only on edges where no queue word is held. Changing it while any word is held does not alter the byte order of the words in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_ce | input | 1 | Output sample clock enable |
| big_endian | input | 1 | Byte extraction order: 1 = most significant byte first |
| y_valid | input | 1 | Luma queue has a word |
| y_data | input | 64 | Luma queue word |
| y_ready | output | 1 | Luma holding register empty; word accepted at the edge |
| cb_valid | input | 1 | Cb queue has a word |
| cb_data | input | 64 | Cb queue word |
| cb_ready | output | 1 | Cb holding register empty |
| cr_valid | input | 1 | Cr queue has a word |
| cr_data | input | 64 | Cr queue word |
| cr_ready | output | 1 | Cr holding register empty |
| vd_out | output | 10 | Display sample, 8-bit value in bits 9:2 |
| vd_valid | output | 1 | vd_out carries a new sample this cycle |

## Verification
A slip in the component slot shows up within one output as a chroma byte in a luma position, or the reverse, and every later sample stays shifted. A wrong byte position inside a lane gives a wrong value on the very next sample from that lane. A holding flag stuck full or cleared early shows up as a ready that never returns, or that rises before eight samples of that component have been sent. A stuck flag also stalls the stream within one 32-sample group. If the mode latch is captured mid-word, the bytes after that point come out reversed.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
  localparam int NUM_LANES = 3;
  localparam int LANE_W    = 2;

  localparam logic [LANE_W-1:0] LANE_Y  = 2'd0;
  localparam logic [LANE_W-1:0] LANE_CB = 2'd1;
  localparam logic [LANE_W-1:0] LANE_CR = 2'd2;

  typedef enum logic [1:0] {
    SLOT_CB = 2'd0,
    SLOT_YA = 2'd1,
    SLOT_CR = 2'd2,
    SLOT_YB = 2'd3
  } slot_e;

  function automatic logic [LANE_W-1:0] lane_of(input slot_e s);
    case (s)
      SLOT_CB: lane_of = LANE_CB;
      SLOT_CR: lane_of = LANE_CR;
      default: lane_of = LANE_Y;
    endcase
  endfunction

  function automatic slot_e slot_after(input slot_e s);
    case (s)
      SLOT_CB: slot_after = SLOT_YA;
      SLOT_YA: slot_after = SLOT_CR;
      SLOT_CR: slot_after = SLOT_YB;
      default: slot_after = SLOT_CB;
    endcase
  endfunction
endpackage

// File: rtl/unpk_lane.sv
module unpk_lane #(
  parameter int SAMPLE_W = 8,
  parameter int SAMPLES  = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         big_endian,
  input  logic                         in_valid,
  input  logic [SAMPLE_W*SAMPLES-1:0]  in_data,
  output logic                         in_ready,
  input  logic                         take,
  output logic                         has_sample,
  output logic [SAMPLE_W-1:0]          sample
);
  localparam int WORD_W = SAMPLE_W * SAMPLES;
  localparam int IDX_W  = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SAMPLES - 1);

  logic [WORD_W-1:0]   word_q;
  logic [IDX_W-1:0]    idx_q;
  logic [IDX_W-1:0]    pos;
  logic                full_q;
  logic [SAMPLE_W-1:0] slice [SAMPLES];

  assign in_ready   = !full_q;
  assign has_sample = full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      idx_q  <= '0;
      word_q <= '0;
    end else if (!full_q) begin
      if (in_valid) begin
        word_q <= in_data;
        full_q <= 1'b1;
        idx_q  <= '0;
      end
    end else if (take) begin
      if (idx_q == LAST) begin
        full_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < SAMPLES; g++) begin : g_slice
      assign slice[g] = word_q[g*SAMPLE_W +: SAMPLE_W];
    end
  endgenerate

  assign pos    = big_endian ? (LAST - idx_q) : idx_q;
  assign sample = slice[pos];
endmodule

// File: rtl/unpk_mode.sv
module unpk_mode #(
  parameter int NUM = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode_in,
  input  logic [NUM-1:0] lanes_busy,
  output logic           mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= mode_in;
    end else if (lanes_busy == '0) begin
      mode_q <= mode_in;
    end
  end
endmodule

// File: rtl/unpk_seq.sv
module unpk_seq
  import unpk_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int OUT_W    = 10
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 ce,
  input  logic [NUM_LANES-1:0]                 lane_has,
  input  logic [NUM_LANES-1:0][SAMPLE_W-1:0]   lane_sample,
  output logic [NUM_LANES-1:0]                 lane_take,
  output logic [OUT_W-1:0]                     out_data,
  output logic                                 out_valid
);
  slot_e             slot_q;
  logic [LANE_W-1:0] sel;
  logic              fire;
  logic [OUT_W-1:0]  shaped;

  always_comb begin
    sel            = lane_of(slot_q);
    fire           = ce && lane_has[sel];
    lane_take      = '0;
    lane_take[sel] = fire;
  end

  generate
    if (OUT_W > SAMPLE_W) begin : g_pad
      assign shaped = {lane_sample[sel], {(OUT_W-SAMPLE_W){1'b0}}};
    end else begin : g_trunc
      assign shaped = lane_sample[sel][SAMPLE_W-1 -: OUT_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q    <= SLOT_CB;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_data <= shaped;
        slot_q   <= slot_after(slot_q);
      end
    end
  end
endmodule

// File: rtl/ycbcr_unpacker.sv
module ycbcr_unpacker
  import unpk_pkg::*;
#(
  parameter int SAMPLE_W         = 8,
  parameter int SAMPLES_PER_WORD = 8,
  parameter int OUT_W            = 10
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   pix_ce,
  input  logic                                   big_endian,
  input  logic                                   y_valid,
  input  logic [SAMPLE_W*SAMPLES_PER_WORD-1:0]   y_data,
  output logic                                   y_ready,
  input  logic                                   cb_valid,
  input  logic [SAMPLE_W*SAMPLES_PER_WORD-1:0]   cb_data,
  output logic                                   cb_ready,
  input  logic                                   cr_valid,
  input  logic [SAMPLE_W*SAMPLES_PER_WORD-1:0]   cr_data,
  output logic                                   cr_ready,
  output logic [OUT_W-1:0]                       vd_out,
  output logic                                   vd_valid
);
  localparam int WORD_W = SAMPLE_W * SAMPLES_PER_WORD;

  logic [NUM_LANES-1:0]               q_valid;
  logic [NUM_LANES-1:0][WORD_W-1:0]   q_data;
  logic [NUM_LANES-1:0]               q_ready;
  logic [NUM_LANES-1:0]               lane_full;
  logic [NUM_LANES-1:0]               lane_take;
  logic [NUM_LANES-1:0][SAMPLE_W-1:0] lane_sample;
  logic                               mode_q;

  always_comb begin
    q_valid          = '0;
    q_data           = '0;
    q_valid[LANE_Y]  = y_valid;
    q_data[LANE_Y]   = y_data;
    q_valid[LANE_CB] = cb_valid;
    q_data[LANE_CB]  = cb_data;
    q_valid[LANE_CR] = cr_valid;
    q_data[LANE_CR]  = cr_data;
  end

  assign y_ready  = q_ready[LANE_Y];
  assign cb_ready = q_ready[LANE_CB];
  assign cr_ready = q_ready[LANE_CR];

  unpk_mode #(.NUM(NUM_LANES)) u_mode (
    .clk       (clk),
    .rst       (rst),
    .mode_in   (big_endian),
    .lanes_busy(lane_full),
    .mode_q    (mode_q)
  );

  genvar l;
  generate
    for (l = 0; l < NUM_LANES; l++) begin : g_lane
      unpk_lane #(.SAMPLE_W(SAMPLE_W), .SAMPLES(SAMPLES_PER_WORD)) u_lane (
        .clk       (clk),
        .rst       (rst),
        .big_endian(mode_q),
        .in_valid  (q_valid[l]),
        .in_data   (q_data[l]),
        .in_ready  (q_ready[l]),
        .take      (lane_take[l]),
        .has_sample(lane_full[l]),
        .sample    (lane_sample[l])
      );
    end
  endgenerate

  unpk_seq #(.SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .ce         (pix_ce),
    .lane_has   (lane_full),
    .lane_sample(lane_sample),
    .lane_take  (lane_take),
    .out_data   (vd_out),
    .out_valid  (vd_valid)
  );
endmodule

// File: rtl/unpk_chk.sv
module unpk_chk #(
  parameter int SAMPLE_W = 8,
  parameter int SAMPLES  = 8,
  parameter int OUT_W    = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             pix_ce,
  input logic [OUT_W-1:0] vd_out,
  input logic             vd_valid,
  input logic             y_valid,
  input logic             y_ready,
  input logic             cb_valid,
  input logic             cb_ready,
  input logic             cr_valid,
  input logic             cr_ready,
  input logic             mode_q,
  input logic [2:0]       lane_full
);
  localparam int CW = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;

  logic [1:0]    out_cnt;
  logic [1:0]    slot_next;
  logic [1:0]    lane_next;
  logic [CW-1:0] y_sent, cb_sent, cr_sent;
  logic [CW-1:0] y_eff, cb_eff, cr_eff;
  logic          is_y, is_cb, is_cr;

  always_comb begin
    is_y      = vd_valid && out_cnt[0];
    is_cb     = vd_valid && (out_cnt == 2'd0);
    is_cr     = vd_valid && (out_cnt == 2'd2);
    slot_next = out_cnt + {1'b0, vd_valid};
    lane_next = slot_next[0] ? 2'd0 : (slot_next[1] ? 2'd2 : 2'd1);
    y_eff     = y_sent  + CW'(is_y);
    cb_eff    = cb_sent + CW'(is_cb);
    cr_eff    = cr_sent + CW'(is_cr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_cnt <= '0;
      y_sent  <= '0;
      cb_sent <= '0;
      cr_sent <= '0;
    end else begin
      out_cnt <= slot_next;
      y_sent  <= y_eff;
      cb_sent <= cb_eff;
      cr_sent <= cr_eff;
    end
  end

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    vd_valid |-> (vd_out[OUT_W-SAMPLE_W-1:0] == '0)); // R5
  AST_VALID_AFTER_CE: assert property (@(posedge clk) disable iff (rst)
    vd_valid |-> $past(pix_ce)); // R6
  AST_Y_LOAD_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (y_valid && y_ready) |-> (y_eff == '0)); // R1
  AST_CB_LOAD_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (cb_valid && cb_ready) |-> (cb_eff == '0)); // R1
  AST_CR_LOAD_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (cr_valid && cr_ready) |-> (cr_eff == '0)); // R1
  AST_STALL_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    (pix_ce && !lane_full[lane_next]) |=> !vd_valid); // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!vd_valid && y_ready && cb_ready && cr_ready)); // R8
  AST_MODE_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_q) |-> ($past(lane_full) == 3'b000)); // R9
endmodule

bind ycbcr_unpacker unpk_chk #(
  .SAMPLE_W(SAMPLE_W), .SAMPLES(SAMPLES_PER_WORD), .OUT_W(OUT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pix_ce   (pix_ce),
  .vd_out   (vd_out),
  .vd_valid (vd_valid),
  .y_valid  (y_valid),
  .y_ready  (y_ready),
  .cb_valid (cb_valid),
  .cb_ready (cb_ready),
  .cr_valid (cr_valid),
  .cr_ready (cr_ready),
  .mode_q   (mode_q),
  .lane_full(lane_full)
);

// File: tb/tb_ycbcr_unpacker.sv
module tb_ycbcr_unpacker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pix_ce = 1'b0;
  logic        big_endian = 1'b0;
  logic        y_valid = 1'b0, cb_valid = 1'b0, cr_valid = 1'b0;
  logic [63:0] y_data = '0, cb_data = '0, cr_data = '0;
  logic        y_ready, cb_ready, cr_ready;
  logic [9:0]  vd_out;
  logic        vd_valid;

  always #2 clk = ~clk;

  ycbcr_unpacker dut (
    .clk(clk), .rst(rst), .pix_ce(pix_ce), .big_endian(big_endian),
    .y_valid(y_valid), .y_data(y_data), .y_ready(y_ready),
    .cb_valid(cb_valid), .cb_data(cb_data), .cb_ready(cb_ready),
    .cr_valid(cr_valid), .cr_data(cr_data), .cr_ready(cr_ready),
    .vd_out(vd_out), .vd_valid(vd_valid)
  );

  // row: {big, rand_ce, starve, spare, cb, y0, y1, cr}
  localparam logic [259:0] VEC [4] = '{
    {4'b0000, 64'hC7C6C5C4C3C2C1C0, 64'h0706050403020100, 64'h0F0E0D0C0B0A0908, 64'hE7E6E5E4E3E2E1E0},
    {4'b1000, 64'hC7C6C5C4C3C2C1C0, 64'h0706050403020100, 64'h0F0E0D0C0B0A0908, 64'hE7E6E5E4E3E2E1E0},
    {4'b0110, 64'h1122334455667788, 64'h99AABBCCDDEEFF10, 64'h2030405060708090, 64'hA1B2C3D4E5F60718},
    {4'b1110, 64'h5A69788796A5B4C3, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'h3C4B5A6978879605}
  };

  logic [63:0] yq [16];
  logic [63:0] cbq [16];
  logic [63:0] crq [16];
  int yn = 0, cbn = 0, crn = 0, yi = 0, cbi = 0, cri = 0;
  logic y_fire = 0, cb_fire = 0, cr_fire = 0;
  int oc = 0;
  logic em = 0, rand_ce = 0, starve = 0, ce_on = 1, ce_last = 0;
  logic [15:0] lfsr = 16'hACE1;
  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pick(input logic [63:0] w, input int k, input logic big);
    int p;
    p = big ? 7 - k : k;
    return w[p*8 +: 8];
  endfunction

  function automatic logic [7:0] exp_at(input int n);
    int c, yx;
    c = n / 4;
    yx = n / 2;
    case (n % 4)
      0: return pick(cbq[c/8], c % 8, em);
      2: return pick(crq[c/8], c % 8, em);
      default: return pick(yq[yx/8], yx % 8, em);
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      yi = 0; cbi = 0; cri = 0; oc = 0;
      y_fire = 0; cb_fire = 0; cr_fire = 0;
      y_valid = 0; cb_valid = 0; cr_valid = 0;
    end else begin
      if (vd_valid) begin
        chk(ce_last, "R6 valid without enable", {63'b0, ce_last}, 64'd1);
        chk(vd_out[1:0] == 2'b00, "R5 low pad bits", {62'b0, vd_out[1:0]}, 64'd0);
        chk(vd_out[9:2] == exp_at(oc), em ? "R4/R3 order big-endian" : "R4/R2 order little-endian",
            {56'b0, vd_out[9:2]}, {56'b0, exp_at(oc)});
        oc++;
      end
      if (y_fire) yi++;
      if (cb_fire) cbi++;
      if (cr_fire) cri++;
      y_valid  = (yi < yn) && !(starve && lfsr[0]);
      cb_valid = (cbi < cbn) && !(starve && lfsr[5]);
      cr_valid = (cri < crn) && !(starve && lfsr[9]);
      y_data   = yq[yi % 16];
      cb_data  = cbq[cbi % 16];
      cr_data  = crq[cri % 16];
      y_fire   = y_valid && y_ready;
      cb_fire  = cb_valid && cb_ready;
      cr_fire  = cr_valid && cr_ready;
    end
    pix_ce  = rand_ce ? lfsr[3] : ce_on;
    ce_last = pix_ce;
    lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  task automatic reset_dut(input logic m);
    @(negedge clk);
    rst = 1; big_endian = m; em = m;
    yn = 0; cbn = 0; crn = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic wait_oc(input int n, input string req);
    int t;
    t = 0;
    while (oc < n && t < 4000) begin
      @(negedge clk);
      t++;
    end
    chk(oc >= n, req, oc, n);
  endtask

  task automatic idle_check(input string req);
    chk(vd_valid == 0, req, vd_valid, 0);
    chk(y_ready && cb_ready && cr_ready, req, {y_ready, cb_ready, cr_ready}, 3'b111);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog (R1..R9 run) actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [259:0] row;
    // R8: reset state
    reset_dut(0);
    @(negedge clk);
    idle_check("R8 reset state");
    chk(vd_out == 0, "R8 reset output", vd_out, 0);

    // table walk: R2 R3 R4 R5 R6 R1
    for (int r = 0; r < 4; r++) begin
      row = VEC[r];
      reset_dut(row[259]);
      rand_ce = row[258]; starve = row[257]; ce_on = 1;
      cbq[0] = row[255:192]; yq[0] = row[191:128]; yq[1] = row[127:64]; crq[0] = row[63:0];
      @(negedge clk);
      cbn = 1; yn = 2; crn = 1;
      wait_oc(32, "R4 group of 32 samples");
      repeat (4) @(negedge clk);
      chk(oc == 32, "R1 no extra samples", oc, 32);
      idle_check("R1 ready after eight samples");
    end
    rand_ce = 0; starve = 0;

    // R7 stall and R1 ready
    reset_dut(0);
    cbq[0] = 64'h8F8E8D8C8B8A8988; yq[0] = 64'h4746454443424140;
    yq[1] = 64'h4F4E4D4C4B4A4948; crq[0] = 64'hD7D6D5D4D3D2D1D0;
    @(negedge clk);
    cbn = 1;
    repeat (8) @(negedge clk);
    chk(oc == 1, "R7 stall without luma", oc, 1);
    chk(vd_valid == 0, "R7 valid low in stall", vd_valid, 0);
    chk(cb_ready == 0, "R1 cb ready low mid-word", cb_ready, 0);
    chk(y_ready == 1, "R1 y ready while empty", y_ready, 1);
    yn = 2; crn = 1;
    wait_oc(32, "R7 resume after stall");

    // R9: mode captured only while idle
    repeat (3) @(negedge clk);
    big_endian = 1; em = 1;
    repeat (3) @(negedge clk);
    cbq[1] = 64'h7766554433221100; yq[2] = 64'hF0E1D2C3B4A59687;
    yq[3] = 64'h1F2E3D4C5B6A7988; crq[1] = 64'h0123456789ABCDEF;
    @(negedge clk);
    cbn = 2; yn = 4; crn = 2;
    wait_oc(40, "R9 second group start");
    big_endian = 0;
    wait_oc(64, "R9 order held mid-word");

    // R8: reset in mid-stream restarts at Cb
    reset_dut(0);
    cbq[0] = 64'h1111111111111110; yq[0] = 64'h2222222222222220;
    yq[1] = 64'h3333333333333330; crq[0] = 64'h4444444444444440;
    @(negedge clk);
    cbn = 1; yn = 2; crn = 1;
    wait_oc(6, "R8 partial group");
    reset_dut(1);
    @(negedge clk);
    idle_check("R8 idle after mid-stream reset");
    row = VEC[3];
    cbq[0] = row[255:192]; yq[0] = row[191:128]; yq[1] = row[127:64]; crq[0] = row[63:0];
    @(negedge clk);
    cbn = 1; yn = 2; crn = 1;
    wait_oc(32, "R8 restart at Cb");

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule